// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps the return addresses of a small microcontroller core in an eight-level hardware stack that software can neither read nor write. When the core executes a subroutine call, or when it acknowledges an interrupt, it presents the current program counter and strobes a push. When it executes a return or a return-from-interrupt, it strobes a pop and takes the saved address from the stack in that same cycle.

The block also decides whether an interrupt may be acknowledged. While every level is occupied, the acknowledge-permission output is low. An unmasked request therefore stays pending in the interrupt controller and is serviced as soon as a return frees a level. A subroutine call made on a full stack is not held off. It overwrites the oldest saved address in a circular fashion, so the newest eight addresses are always the ones kept, and the block raises a one-cycle overflow flag. A return on an empty stack raises a one-cycle underflow flag and changes no state.

Top module: `ret_addr_stack`

## Requirements
- R1: During and right after reset the stack is empty: `empty`=1, `full`=0, `int_ack_allow`=1, `overflow`=0, `underflow`=0.
- R2: Pops return the pushed addresses newest first. A pop sees the address on `pop_pc` combinationally, in the same cycle that `pop` is high.
- R3: The occupancy rises by one for each accepted push and falls by one for each pop on a non-empty stack. It saturates at 8. `full` is 1 exactly when 8 entries are held, and `empty` is 1 exactly when none are held.
- R4: `int_ack_allow` is 1 exactly when fewer than 8 entries are held.
- R5: A `push_call` on a full stack is still stored. The oldest entry is lost, the stack stays full, and `overflow` is 1 for the single cycle after the push. The following eight pops return the newest eight addresses.
- R6: A `push_irq` on a full stack is ignored. Contents and occupancy do not change and `overflow` stays 0.
- R7: A `pop` on an empty stack leaves the stack empty and the pointer unchanged, and raises `underflow` for the single cycle after it. Straight after reset the address it returns is 0.
- R8: A pop on a full stack raises `int_ack_allow` in the next cycle.
- R9: A `push_irq` on a non-full stack stores its address exactly like a call and counts toward the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_call | input | 1 | Subroutine-call push strobe |
| push_irq | input | 1 | Interrupt-acknowledge push strobe |
| push_pc | input | PC_W | Address to save on a push |
| pop | input | 1 | Return strobe |
| pop_pc | output | PC_W | Address on top of the stack (valid while `pop` is high) |
| full | output | 1 | All levels occupied |
| empty | output | 1 | No level occupied |
| int_ack_allow | output | 1 | Interrupt acknowledge permitted |
| overflow | output | 1 | One-cycle pulse after a call on a full stack |
| underflow | output | 1 | One-cycle pulse after a pop on an empty stack |

## Verification
The assertions assume that the core never strobes a push and `pop` in the same cycle, and that it raises at most one of `push_call` and `push_irq` at a time. The bench drives exactly one strobe per operation, at the falling edge, and clears it at the next falling edge. The bench also issues `push_irq` on a full stack on purpose. This checks that the gate drops the request, whereas a well-behaved interrupt controller would never send it.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Increment a slot index modulo the stack depth.
  function automatic int wrap_inc(int p, int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Decrement a slot index modulo the stack depth.
  function automatic int wrap_dec(int p, int depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  // Occupancy after an accepted push: stops at the depth.
  function automatic int sat_inc(int c, int lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

  // Occupancy after a pop: stops at zero.
  function automatic int floor_dec(int c);
    return (c == 0) ? 0 : c - 1;
  endfunction

endpackage

// File: rtl/ras_store.sv
module ras_store #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_slot,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [PTR_W-1:0] rd_slot,
  output logic [PC_W-1:0]  rd_data
);

  logic [PC_W-1:0] slot_q [DEPTH];

  // One register per level, each with its own decoded write enable.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= wr_data;
    end
  end

  // Combinational read port: the pop data is valid in the pop cycle.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_slot == PTR_W'(i)) rd_data = slot_q[i];
    end
  end

endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_call,
  input  logic             push_irq,
  input  logic             pop,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_slot,
  output logic [PTR_W-1:0] rd_slot,
  output logic [CNT_W-1:0] occ,
  output logic             is_full,
  output logic             is_empty,
  output logic             ovf_evt,
  output logic             unf_evt,
  output logic             ovf_q,
  output logic             unf_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             irq_take, pop_take;

  assign is_full  = (cnt_q == CNT_MAX);
  assign is_empty = (cnt_q == '0);

  // Interrupt pushes are dropped when no level is free; calls never are.
  assign irq_take = push_irq && !is_full;
  assign wr_en    = push_call || irq_take;
  assign pop_take = pop && !is_empty && !wr_en;

  assign ovf_evt = push_call && is_full;
  assign unf_evt = pop && is_empty && !wr_en;

  assign wr_slot = ptr_q;
  assign rd_slot = PTR_W'(ras_pkg::wrap_dec(int'(ptr_q), DEPTH));
  assign occ     = cnt_q;

  always_comb begin
    ptr_nx = ptr_q;
    cnt_nx = cnt_q;
    if (wr_en) begin
      ptr_nx = PTR_W'(ras_pkg::wrap_inc(int'(ptr_q), DEPTH));
      cnt_nx = CNT_W'(ras_pkg::sat_inc(int'(cnt_q), DEPTH));
    end else if (pop_take) begin
      ptr_nx = rd_slot;
      cnt_nx = CNT_W'(ras_pkg::floor_dec(int'(cnt_q)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ptr_q <= ptr_nx;
      cnt_q <= cnt_nx;
      ovf_q <= ovf_evt;
      unf_q <= unf_evt;
    end
  end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int PC_W  = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_call,
  input  logic            push_irq,
  input  logic [PC_W-1:0] push_pc,
  input  logic            pop,
  output logic [PC_W-1:0] pop_pc,
  output logic            full,
  output logic            empty,
  output logic            int_ack_allow,
  output logic            overflow,
  output logic            underflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Internal events, named for the bound checker.
  logic             wr_en;
  logic [PTR_W-1:0] wr_slot, rd_slot;
  logic [CNT_W-1:0] occ_count;
  logic             ovf_evt, unf_evt;

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_call(push_call),
    .push_irq (push_irq),
    .pop      (pop),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .rd_slot  (rd_slot),
    .occ      (occ_count),
    .is_full  (full),
    .is_empty (empty),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt),
    .ovf_q    (overflow),
    .unf_q    (underflow)
  );

  ras_store #(.PC_W(PC_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_slot(wr_slot),
    .wr_data(push_pc),
    .rd_slot(rd_slot),
    .rd_data(pop_pc)
  );

  // Acknowledge gate: read from the registered occupancy.
  assign int_ack_allow = (occ_count < CNT_W'(DEPTH));

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_call,
  input logic             push_irq,
  input logic             pop,
  input logic             wr_en,
  input logic             full,
  input logic             empty,
  input logic             int_ack_allow,
  input logic             overflow,
  input logic             underflow,
  input logic             ovf_evt,
  input logic [CNT_W-1:0] occ_count
);

  a_r1_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ_count <= CNT_W'(DEPTH));

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full) |=> (occ_count == $past(occ_count) + 1'b1));

  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_en && !empty) |=> (occ_count == $past(occ_count) - 1'b1));

  a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack_allow == !full);

  a_r5_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (push_call && full) |=> (overflow && full));

  a_r5_ovf_only_then: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(ovf_evt));

  a_r6_irq_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push_irq && !push_call && full) |=> (!overflow && $stable(occ_count)));

  a_r7_unf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_en && empty) |=> (underflow && empty));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_en && full) |=> int_ack_allow);

endmodule

bind ret_addr_stack ras_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_call    (push_call),
  .push_irq     (push_irq),
  .pop          (pop),
  .wr_en        (wr_en),
  .full         (full),
  .empty        (empty),
  .int_ack_allow(int_ack_allow),
  .overflow     (overflow),
  .underflow    (underflow),
  .ovf_evt      (ovf_evt),
  .occ_count    (occ_count)
);

// File: tb/ret_addr_stack_test.sv
`timescale 1ns/1ps
module ret_addr_stack_test;
  localparam int PC_W  = 13;
  localparam int DEPTH = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            push_call = 1'b0, push_irq = 1'b0, pop = 1'b0;
  logic [PC_W-1:0] push_pc = '0;
  logic [PC_W-1:0] pop_pc;
  logic            full, empty, int_ack_allow, overflow, underflow;

  int tests = 0, fails = 0;
  logic [PC_W-1:0] m [DEPTH];   // newest at index 0
  int  mcnt = 0;
  bit  fresh = 1'b1;

  always #2.5 clk = ~clk;

  ret_addr_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) uut (.*);

  task automatic check(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_status(bit ovf, bit unf);
    check("R3 full",  int'(full),  int'(mcnt == DEPTH));
    check("R3 empty", int'(empty), int'(mcnt == 0));
    check("R4 int_ack_allow", int'(int_ack_allow), int'(mcnt < DEPTH));
    check("R5 overflow",  int'(overflow),  int'(ovf));
    check("R7 underflow", int'(underflow), int'(unf));
  endtask

  // One operation, started and finished at a falling edge.
  task automatic op(bit c, bit i, bit p, int pc);
    bit ovf, unf;
    push_call = c; push_irq = i; pop = p; push_pc = PC_W'(pc);
    #1;
    ovf = c && (mcnt == DEPTH);
    unf = p && (mcnt == 0);
    if (p && mcnt > 0)  check("R2 pop data", int'(pop_pc), int'(m[0]));
    if (p && mcnt == 0 && fresh) check("R7 empty pop data", int'(pop_pc), 0);
    if (c || (i && mcnt < DEPTH)) begin
      for (int k = DEPTH - 1; k > 0; k--) m[k] = m[k-1];
      m[0] = PC_W'(pc);
      if (mcnt < DEPTH) mcnt++;
      fresh = 1'b0;
    end else if (p && mcnt > 0) begin
      for (int k = 0; k < DEPTH - 1; k++) m[k] = m[k+1];
      mcnt--;
    end
    @(posedge clk);
    @(negedge clk);
    push_call = 1'b0; push_irq = 1'b0; pop = 1'b0;
    #1;
    check_status(ovf, unf);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mcnt = 0; fresh = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1 reset empty", int'(empty), 1);
    check("R1 reset full", int'(full), 0);
    check("R1 reset allow", int'(int_ack_allow), 1);
    check("R1 reset flags", int'({overflow, underflow}), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // Sweep of fill levels 0..11 with calls, then drain plus one extra pop.
    for (int n = 0; n <= 11; n++) begin
      do_reset();
      for (int j = 0; j < n; j++) op(1, 0, 0, n * 64 + j + 1);    // R5 past 8
      for (int j = 0; j <= DEPTH; j++) op(0, 0, 1, 0);           // R2, R7
    end

    // R9: interrupt pushes on a non-full stack, mixed with calls.
    do_reset();
    for (int j = 0; j < DEPTH; j++) op(j[0], !j[0], 0, 100 + j);
    // R6: interrupt push while full is dropped.
    op(0, 1, 0, 999);
    check("R6 still full", int'(full), 1);
    // R8: pop on full frees a level and reopens the gate.
    op(0, 0, 1, 0);
    check("R8 allow after pop", int'(int_ack_allow), 1);
    for (int j = 0; j < DEPTH; j++) op(0, 0, 1, 0);

    // Alternating push/pop patterns at several depths.
    do_reset();
    for (int r = 0; r < 20; r++) begin
      op(1, 0, 0, 2000 + r * 3);
      op(0, 1, 0, 2001 + r * 3);
      op(0, 0, 1, 0);
    end
    for (int j = 0; j < DEPTH + 1; j++) op(0, 0, 1, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule